// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock from a faster base clock through two cascaded division stages. The first stage is a power-of-two prescaler selected by a one-hot code. The second is a linear divisor from 1 to 16, coded as its factor minus one. A double-data-rate flag halves the prescale that a given code selects. The overall ratio is the product of both stages. The output has a near-even duty cycle. At the one ratio that cannot be divided, a ratio of one, it is the gated base clock itself.

Software selects the codes while the clock enable is low, then raises the enable. The divider picks up a new setting only while its output is stopped. It stops only at the end of a low phase, so a change never produces a runt pulse. A settled flag rises once the first complete output period after start has gone by.

Top module: `sdclk_divider`

## Requirements
- R1: After reset the card clock output and the settled flag are both low, and they stay low while the enable is low.
- R2: With the mode flag low and a one-hot prescaler code C (bit k set selects 2^(k+1)), the output period is 2*C*(D+1) base cycles, where D is the 4-bit divisor code.
- R3: With the mode flag high, the prescale is C itself instead of 2*C, so the period is C*(D+1) base cycles.
- R4: A prescaler code of zero or with two or more bits set behaves exactly like code 0x01.
- R5: For a ratio N of 2 or more, each period holds the output high for floor(N/2) base cycles and low for the remaining N-floor(N/2).
- R6: For a ratio of 1, the output follows the base clock (high in its high half, low in its low half) while enabled.
- R7: Codes and mode flag are taken only while the output is stopped; changing them while enabled has no effect until the enable has been dropped and raised again.
- R8: Dropping the enable lets the current high phase run to its full length, ends at a period boundary, then holds the output low.
- R9: The settled flag rises N+1 base edges after the enable is seen (counting the first output edge as edge 1) and is low whenever the output is stopped.
- R10: The first base edge after start drives the output high, beginning a full-length high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pre_code_i | input | 8 | One-hot prescaler code |
| div_code_i | input | 4 | Linear divisor minus one |
| ddr_i | input | 1 | Double-data-rate mode, halves the prescale |
| clk_en_i | input | 1 | Card clock enable |
| card_clk_o | output | 1 | Divided card clock |
| stable_o | output | 1 | Clock settled flag |

## Verification
The bench measures the high and low run lengths of the output for odd and even ratios. A design that rounds the high phase the wrong way, or that drops a cycle at the wrap, shows up here. It covers invalid prescaler codes, the double-data-rate halving, the largest ratio of 4096 and the ratio-of-one pass-through, where a sampled divider would stay low or toggle at half rate. It changes the codes while the clock runs, which exposes a design that reloads its ratio without a stop. It drops the enable during a high phase, which shows whether the design cuts the pulse short. It counts the edges up to the settled flag, which reveals an off-by-one in that flag.

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int PW = 8,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pre_code_i,
  input  logic [DW-1:0] div_code_i,
  input  logic          ddr_i,
  input  logic          clk_en_i,
  output logic          card_clk_o,
  output logic          stable_o
);
  localparam int NW = PW + DW + 2;

  logic [PW-1:0] code_ok;
  logic [PW:0]   pscale;
  logic [NW-1:0] n_req, n_act, cnt, cnt_nxt, hi;
  logic          run, out_q, stable_q, gate_n, last;

  assign code_ok = $onehot(pre_code_i) ? pre_code_i : PW'(1);
  assign pscale  = ddr_i ? {1'b0, code_ok} : {code_ok, 1'b0};
  assign n_req   = NW'(pscale) * NW'({1'b0, div_code_i} + (DW+1)'(1));
  assign hi      = n_act >> 1;
  assign last    = (cnt == n_act - NW'(1));
  assign cnt_nxt = last ? '0 : cnt + NW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run      <= 1'b0;
      cnt      <= '0;
      out_q    <= 1'b0;
      stable_q <= 1'b0;
      n_act    <= NW'(2);
    end else if (!run) begin
      cnt      <= '0;
      stable_q <= 1'b0;
      n_act    <= n_req;
      run      <= clk_en_i;
      out_q    <= clk_en_i && (n_req != NW'(1));
    end else if (!clk_en_i && last) begin
      run      <= 1'b0;
      cnt      <= '0;
      out_q    <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      cnt   <= cnt_nxt;
      out_q <= (cnt_nxt < hi);
      if (last) stable_q <= 1'b1;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_n <= 1'b0;
    else         gate_n <= run && (n_act == NW'(1));
  end

  assign card_clk_o = (clk_i & gate_n) | out_q;
  assign stable_o   = stable_q;

  a_r7_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && $past(run) |-> $stable(n_act));
  a_r8_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run) |-> !out_q);
  a_r9_stable_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !stable_q);
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> cnt < n_act);
  a_r6_gate_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_n |-> !out_q);
endmodule

// File: tb/tb_sdclk_divider.sv
module tb_sdclk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pre = 8'h01;
  logic [3:0] dv = 4'd0;
  logic       ddr = 1'b0;
  logic       en = 1'b0;
  logic       cclk, stb;
  int n_chk = 0, n_bad = 0, cur_n = 2;

  always #10 clk = ~clk;

  sdclk_divider dut (.clk_i(clk), .rst_ni(rst_n), .pre_code_i(pre),
    .div_code_i(dv), .ddr_i(ddr), .clk_en_i(en), .card_clk_o(cclk),
    .stable_o(stb));

  function automatic int exp_n(logic [7:0] c, logic [3:0] d, logic m);
    int p;
    p = ($countones(c) == 1) ? int'(c) : 1;
    if (!m) p = p * 2;
    return p * (int'(d) + 1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic run_cfg(logic [7:0] c, logic [3:0] d, logic m, string req);
    int n, k, h, l, first;
    en = 1'b0;
    repeat (cur_n + 4) step();
    check("R1", int'(stb), 0);
    pre = c; dv = d; ddr = m; en = 1'b1;
    n = exp_n(c, d, m);
    cur_n = n;
    k = 0; first = -1;
    do begin
      step(); k++;
      if (k == 1) first = int'(cclk);
    end while (!stb && k < 5000);
    check("R9", k, n + 1);
    if (n >= 2) begin
      check("R10", first, 1);
      h = 0; l = 0;
      while (cclk && h < 5000) begin h++; step(); end
      while (!cclk && l < 5000) begin l++; step(); end
      check("R5", h, n / 2);
      check("R5", l, n - n / 2);
      check(req, h + l, n);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int h, z;
    void'($urandom(32'd4711));
    repeat (3) step();
    check("R1", int'(cclk), 0);
    check("R1", int'(stb), 0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1", int'(cclk), 0);
    check("R1", int'(stb), 0);

    run_cfg(8'h01, 4'd0, 1'b0, "R2");
    run_cfg(8'h01, 4'd2, 1'b0, "R2");
    run_cfg(8'h04, 4'd2, 1'b1, "R3");
    run_cfg(8'h02, 4'd4, 1'b1, "R3");
    run_cfg(8'h00, 4'd3, 1'b0, "R4");
    run_cfg(8'h06, 4'd1, 1'b0, "R4");
    run_cfg(8'h81, 4'd0, 1'b1, "R4");
    for (int i = 0; i < 8; i++) begin
      logic [7:0] c; logic [3:0] d; logic m;
      c = 8'h01 << ($urandom % 5);
      d = 4'($urandom % 16);
      m = 1'($urandom % 2);
      run_cfg(c, d, m, m ? "R3" : "R2");
    end

    // R6: ratio of one follows the base clock
    run_cfg(8'h01, 4'd0, 1'b1, "R6");
    for (int i = 0; i < 4; i++) begin
      check("R6", int'(cclk), 1);
      #10;
      check("R6", int'(cclk), 0);
      #10;
    end
    en = 1'b0;
    repeat (3) step();
    check("R8", int'(cclk), 0);
    #10 check("R8", int'(cclk), 0);
    #10;

    // R7: change codes while running, ratio 8 must persist
    run_cfg(8'h02, 4'd1, 1'b0, "R2");
    pre = 8'h40; dv = 4'd15;
    begin
      int hh = 0, ll = 0;
      while (cclk && hh < 5000) begin hh++; step(); end
      while (!cclk && ll < 5000) begin ll++; step(); end
      check("R7", hh + ll, 8);
    end
    run_cfg(8'h40, 4'd15, 1'b0, "R7");

    // R8: drop enable at start of high phase with ratio 6
    run_cfg(8'h01, 4'd2, 1'b0, "R2");
    en = 1'b0;
    h = 1; step();
    while (cclk && h < 100) begin h++; step(); end
    check("R8", h, 3);
    z = 0;
    for (int i = 0; i < 20; i++) begin
      if (cclk) z++;
      step();
    end
    check("R8", z, 0);
    check("R9", int'(stb), 0);

    // largest ratio
    run_cfg(8'h80, 4'd15, 1'b0, "R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule